// File: doc/BRIEF.md
# Unique Device Identifier Readout Controller

This block fetches a 64-bit unique device identifier from a fuse-style storage element over a small serial request/bit handshake, and presents it as a parallel word with a valid flag. The word stays zero and the flag stays low until every bit of the identifier has arrived. The new value and the flag then appear together in one clock cycle.

A build-time parameter selects how a read begins. In trigger mode, a read starts on a falling edge of the trigger input, but only after the trigger has been high for at least three synchronized clock cycles. In automatic mode, a read starts by itself when the reset input is released. In either mode only one read is allowed per reset. Once an identifier has been loaded, the block ignores further triggers and keeps the value until the next qualified reset.

The reset input is synchronous. It is qualified by length: a pulse shorter than the configured minimum is ignored. A qualified reset aborts any transfer in progress and throws away the bits already received.

Top module: `uid_readout`

## Requirements
- R1: After a qualified reset, chip_id is all zeros, id_valid is 0 and fuse_req is 0.
- R2: A reset pulse held high for fewer than 10 consecutive clock edges has no effect: a loaded chip_id and id_valid keep their values.
- R3: When rst_in has been sampled high on 10 consecutive edges, the outputs are cleared on that 10th edge, while rst_in is still high.
- R4: In trigger mode, read_trig held high for 3 or more cycles and then driven low starts a read: fuse_req rises within a few cycles.
- R5: A read_trig pulse shorter than 3 cycles does not start a read, and fuse_req stays 0.
- R6: The fuse bits arrive most significant first, one per fuse_bit_vld pulse, so the first bit received ends up in chip_id[63].
- R7: While a read is in progress, id_valid is 0 and chip_id stays all zeros; chip_id and id_valid change in the same cycle.
- R8: fuse_req stays high from the start of a read until the 64th bit is taken, and is low in the cycle where id_valid first reads 1.
- R9: After a completed read, further trigger edges are ignored: fuse_req stays 0 and chip_id holds its value.
- R10: In automatic mode, a read starts without any trigger when rst_in is released after a qualified reset, and it ends with the correct identifier.
- R11: A qualified reset during a read drops fuse_req. The partial bits are discarded, and the next read returns the full identifier.
- R12: fuse_bit_vld pulses outside a read are ignored: they neither load chip_id nor advance the bit count of the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Synchronous reset request; acts only after the minimum pulse length |
| read_trig | input | 1 | Read trigger, asynchronous; a qualified falling edge starts a read (trigger mode) |
| fuse_bit | input | 1 | Serial identifier bit from the fuse side |
| fuse_bit_vld | input | 1 | One-cycle strobe marking fuse_bit as valid |
| fuse_req | output | 1 | High while the block wants identifier bits |
| chip_id | output | 64 | Loaded identifier, zero until a read completes |
| id_valid | output | 1 | High once all identifier bits are loaded |

## Verification
The assertions assume that a reset request still being counted is not yet in effect, so they are disabled while one is pending. They also assume the fuse side sends bits only while fuse_req is high, except in a deliberate stray-strobe case. The bench fuse models answer fuse_req with one bit every second cycle and stop after 64 bits. Stray strobes are injected only in the test that checks they are ignored. The bench changes all inputs at falling clock edges, holds every reset it means to qualify for at least 10 cycles, and drives the trigger low in automatic mode.

// File: rtl/uid_pkg.sv
package uid_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARM  = 3'd1,
        ST_READ = 3'd2,
        ST_DONE = 3'd3,
        ST_HOLD = 3'd4
    } uid_state_e;
endpackage

// File: rtl/uid_rst_qual.sv
module uid_rst_qual #(
    parameter int MIN_CYC = 10
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_hit,
    output logic rst_pend
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] MIN_V  = CW'(MIN_CYC);
    localparam logic [CW-1:0] LAST_V = CW'(MIN_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } rq_regs_t;

    rq_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!rst_in)
            r_d.cnt = '0;
        else if (r_q.cnt != MIN_V)
            r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign rst_hit  = rst_in && (r_q.cnt >= LAST_V);
    assign rst_pend = rst_in && !rst_hit;

    // R3: qualification always follows a cycle in which the reset was still being counted
    p_hit_after_count_r3: assert property (@(posedge clk) disable iff (!rst_in)
        $rose(rst_hit) |-> $past(rst_pend));
endmodule

// File: rtl/uid_trig_qual.sv
module uid_trig_qual #(
    parameter int MIN_HIGH = 3
) (
    input  logic clk,
    input  logic clr,
    input  logic trig_in,
    output logic trig_lvl,
    output logic start
);
    localparam int CW = $clog2(MIN_HIGH + 1);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_HIGH);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
    } tq_regs_t;

    tq_regs_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = trig_in;
        r_d.s2 = r_q.s1;
        if (clr || !r_q.s2)
            r_d.cnt = '0;
        else if (r_q.cnt != MIN_V)
            r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign trig_lvl = r_q.s2;
    assign start    = !r_q.s2 && (r_q.cnt == MIN_V);

    // R5: an accepted fall is preceded by three high synchronized samples (default minimum)
    p_fall_after_high_r5: assert property (@(posedge clk) disable iff (clr)
        start |-> ($past(r_q.s2, 1) && $past(r_q.s2, 2) && $past(r_q.s2, 3)));
endmodule

// File: rtl/uid_shifter.sv
module uid_shifter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         en,
    input  logic         vld,
    input  logic         bit_in,
    output logic         done,
    output logic [W-1:0] word
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_V = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
    } sh_regs_t;

    sh_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr || !en) begin
            r_d.sh  = '0;
            r_d.cnt = '0;
        end else if (vld) begin
            r_d.sh  = {r_q.sh[W-2:0], bit_in};
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign done = en && vld && (r_q.cnt == LAST_V);
    assign word = {r_q.sh[W-2:0], bit_in};

    // R12: with the transfer disabled the bit count cannot advance
    p_count_idle_r12: assert property (@(posedge clk) disable iff (clr)
        (!en && !$past(en)) |-> (r_q.cnt == '0));
endmodule

// File: rtl/uid_readout.sv
module uid_readout #(
    parameter int ID_W       = 64,
    parameter int RST_MIN    = 10,
    parameter int TRIG_MIN   = 3,
    parameter bit AUTO_START = 1'b0
) (
    input  logic            clk,
    input  logic            rst_in,
    input  logic            read_trig,
    input  logic            fuse_bit,
    input  logic            fuse_bit_vld,
    output logic            fuse_req,
    output logic [ID_W-1:0] chip_id,
    output logic            id_valid
);
    import uid_pkg::*;

    typedef struct packed {
        uid_state_e      state;
        logic [ID_W-1:0] id;
        logic            valid;
    } top_regs_t;

    top_regs_t r_q, r_d;

    logic            rst_hit, rst_pend;
    logic            trig_lvl, trig_start;
    logic            sh_done;
    logic [ID_W-1:0] sh_word;
    logic            in_read;

    uid_rst_qual #(.MIN_CYC(RST_MIN)) u_rq (
        .clk     (clk),
        .rst_in  (rst_in),
        .rst_hit (rst_hit),
        .rst_pend(rst_pend)
    );

    uid_trig_qual #(.MIN_HIGH(TRIG_MIN)) u_tq (
        .clk     (clk),
        .clr     (rst_hit),
        .trig_in (read_trig),
        .trig_lvl(trig_lvl),
        .start   (trig_start)
    );

    assign in_read = (r_q.state == ST_READ) && !rst_hit;

    uid_shifter #(.W(ID_W)) u_sh (
        .clk   (clk),
        .clr   (rst_hit),
        .en    (in_read),
        .vld   (fuse_bit_vld),
        .bit_in(fuse_bit),
        .done  (sh_done),
        .word  (sh_word)
    );

    always_comb begin
        r_d = r_q;
        if (rst_hit) begin
            r_d.state = ST_HOLD;
            r_d.id    = '0;
            r_d.valid = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: if (!AUTO_START && trig_lvl) r_d.state = ST_ARM;
                ST_ARM: begin
                    if (trig_start)     r_d.state = ST_READ;
                    else if (!trig_lvl) r_d.state = ST_IDLE;
                end
                ST_READ: begin
                    if (sh_done) begin
                        r_d.id    = sh_word;
                        r_d.valid = 1'b1;
                        r_d.state = ST_DONE;
                    end
                end
                ST_DONE: r_d.state = ST_DONE;
                ST_HOLD: if (!rst_in) r_d.state = AUTO_START ? ST_READ : ST_IDLE;
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign fuse_req = (r_q.state == ST_READ);
    assign chip_id  = r_q.id;
    assign id_valid = r_q.valid;

    // R1 R3: a qualified reset clears every output on the next cycle
    p_clear_on_hit_r3: assert property (@(posedge clk) disable iff (rst_pend)
        rst_hit |=> (!id_valid && chip_id == '0 && !fuse_req));
    // R9: a loaded identifier is held until a qualified reset
    p_hold_id_r9: assert property (@(posedge clk) disable iff (rst_pend)
        (id_valid && !rst_hit) |=> (id_valid && $stable(chip_id)));
    // R8: the request is never active alongside a valid identifier
    p_req_excl_valid_r8: assert property (@(posedge clk) disable iff (rst_pend)
        fuse_req |-> !id_valid);
    // R7: no partial value is visible before the flag
    p_zero_until_valid_r7: assert property (@(posedge clk) disable iff (rst_pend)
        !id_valid |-> (chip_id == '0));
    // R7: the flag rises only at the end of a transfer
    p_rise_from_read_r7: assert property (@(posedge clk) disable iff (rst_pend)
        $rose(id_valid) |-> $past(fuse_req));
    // R10: leaving the held reset starts a read exactly in automatic mode
    p_release_start_r10: assert property (@(posedge clk) disable iff (rst_pend)
        (r_q.state == ST_HOLD && !rst_in) |=> (fuse_req == AUTO_START));
endmodule

// File: tb/uid_readout_test.sv
module uid_fuse_model #(
    parameter logic [63:0] ID = 64'h0
) (
    input  logic clk,
    input  logic req,
    output logic bit_o,
    output logic vld_o,
    output int   sent
);
    logic phase;
    initial begin
        bit_o = 1'b0;
        vld_o = 1'b0;
        sent  = 0;
        phase = 1'b0;
    end
    always @(negedge clk) begin
        if (!req) begin
            sent  <= 0;
            vld_o <= 1'b0;
            phase <= 1'b0;
        end else if (sent < 64 && phase) begin
            vld_o <= 1'b1;
            bit_o <= ID[63 - sent];
            sent  <= sent + 1;
            phase <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            phase <= 1'b1;
        end
    end
endmodule

module uid_readout_test;
    localparam logic [63:0] ID_A = 64'hA5C3_0F1E_9B27_6D48;
    localparam logic [63:0] ID_B = 64'h1357_9BDF_2468_ACE0;

    logic        clk = 1'b0;
    logic        rst_in = 1'b0;
    logic        read_trig = 1'b0;
    logic        stray_vld = 1'b0;
    logic        stray_bit = 1'b0;
    logic        f_bit, f_vld, m_bit, m_vld;
    logic        fuse_req;
    logic [63:0] chip_id;
    logic        id_valid;
    int          m_sent;

    logic        a_bit, a_vld, a_req, a_valid;
    logic [63:0] a_id;
    int          a_sent;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uid_fuse_model #(.ID(ID_A)) u_fa (.clk(clk), .req(fuse_req), .bit_o(m_bit), .vld_o(m_vld), .sent(m_sent));
    uid_fuse_model #(.ID(ID_B)) u_fb (.clk(clk), .req(a_req), .bit_o(a_bit), .vld_o(a_vld), .sent(a_sent));

    assign f_vld = m_vld | stray_vld;
    assign f_bit = stray_vld ? stray_bit : m_bit;

    uid_readout #(.AUTO_START(1'b0)) uut (
        .clk(clk), .rst_in(rst_in), .read_trig(read_trig),
        .fuse_bit(f_bit), .fuse_bit_vld(f_vld),
        .fuse_req(fuse_req), .chip_id(chip_id), .id_valid(id_valid)
    );

    uid_readout #(.AUTO_START(1'b1)) uut_auto (
        .clk(clk), .rst_in(rst_in), .read_trig(1'b0),
        .fuse_bit(a_bit), .fuse_bit_vld(a_vld),
        .fuse_req(a_req), .chip_id(a_id), .id_valid(a_valid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic hold_reset(input int n);
        rst_in = 1'b1;
        repeat (n) @(negedge clk);
        rst_in = 1'b0;
    endtask

    task automatic pulse_trig(input int n);
        read_trig = 1'b1;
        repeat (n) @(negedge clk);
        read_trig = 1'b0;
    endtask

    task automatic t_reset_state();
        hold_reset(12);
        check(chip_id == '0, "R1 chip_id", chip_id, 64'h0);
        check(id_valid == 1'b0, "R1 id_valid", 64'(id_valid), 64'h0);
        check(fuse_req == 1'b0, "R1 fuse_req", 64'(fuse_req), 64'h0);
        check(a_valid == 1'b0, "R1 auto id_valid", 64'(a_valid), 64'h0);
    endtask

    task automatic t_short_trig();
        bit seen = 1'b0;
        pulse_trig(2);
        repeat (12) begin
            @(negedge clk);
            if (fuse_req) seen = 1'b1;
        end
        check(!seen, "R5 short trigger ignored", 64'(seen), 64'h0);
    endtask

    task automatic t_stray_vld();
        stray_bit = 1'b1;
        repeat (5) begin
            stray_vld = 1'b1;
            @(negedge clk);
            stray_vld = 1'b0;
            @(negedge clk);
        end
        check(id_valid == 1'b0 && chip_id == '0, "R12 stray strobes ignored", chip_id, 64'h0);
    endtask

    task automatic do_read(input string tag);
        bit started = 1'b0;
        bit leak = 1'b0;
        bit prev_req = 1'b0;
        int wait_n = 0;
        pulse_trig(4);
        while (!fuse_req && wait_n < 10) begin
            @(negedge clk);
            wait_n++;
        end
        started = fuse_req;
        check(started, {tag, " R4 read started"}, 64'(fuse_req), 64'h1);
        wait_n = 0;
        while (!id_valid && wait_n < 400) begin
            if (chip_id != '0) leak = 1'b1;
            prev_req = fuse_req;
            @(negedge clk);
            wait_n++;
        end
        check(!leak, {tag, " R7 chip_id zero during read"}, 64'(leak), 64'h0);
        check(id_valid == 1'b1, {tag, " R7 id_valid set"}, 64'(id_valid), 64'h1);
        check(chip_id == ID_A, {tag, " R6 identifier msb first"}, chip_id, ID_A);
        check(prev_req && !fuse_req, {tag, " R8 request drops with valid"},
              {62'h0, prev_req, fuse_req}, 64'h2);
    endtask

    task automatic t_retrigger();
        bit seen = 1'b0;
        pulse_trig(5);
        repeat (20) begin
            @(negedge clk);
            if (fuse_req) seen = 1'b1;
        end
        check(!seen, "R9 no second read", 64'(seen), 64'h0);
        check(chip_id == ID_A && id_valid, "R9 identifier held", chip_id, ID_A);
    endtask

    task automatic t_short_reset();
        hold_reset(9);
        @(negedge clk);
        check(chip_id == ID_A, "R2 short reset keeps id", chip_id, ID_A);
        check(id_valid == 1'b1, "R2 short reset keeps valid", 64'(id_valid), 64'h1);
    endtask

    task automatic t_long_reset();
        rst_in = 1'b1;
        repeat (9) @(negedge clk);
        check(id_valid == 1'b1, "R3 not cleared after 9 edges", 64'(id_valid), 64'h1);
        @(negedge clk);
        check(id_valid == 1'b0 && chip_id == '0, "R3 cleared on 10th edge", chip_id, 64'h0);
        repeat (2) @(negedge clk);
        rst_in = 1'b0;
        @(negedge clk);
        check(chip_id == '0 && !fuse_req, "R1 state after long reset", chip_id, 64'h0);
    endtask

    task automatic t_abort();
        pulse_trig(3);
        repeat (30) @(negedge clk);
        check(fuse_req == 1'b1, "R11 read in progress", 64'(fuse_req), 64'h1);
        rst_in = 1'b1;
        repeat (9) @(negedge clk);
        check(fuse_req == 1'b1, "R11 request kept before qualification", 64'(fuse_req), 64'h1);
        @(negedge clk);
        check(fuse_req == 1'b0, "R11 request dropped", 64'(fuse_req), 64'h0);
        rst_in = 1'b0;
        repeat (3) @(negedge clk);
        check(chip_id == '0 && !id_valid, "R11 partial discarded", chip_id, 64'h0);
        do_read("R11 reread");
    endtask

    task automatic t_auto();
        int wait_n = 0;
        while (!a_valid && wait_n < 400) begin
            @(negedge clk);
            wait_n++;
        end
        check(a_valid == 1'b1, "R10 auto read completes", 64'(a_valid), 64'h1);
        check(a_id == ID_B, "R10 auto identifier", a_id, ID_B);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset_state();
        t_short_trig();
        t_stray_vld();
        do_read("first");
        t_retrigger();
        t_short_reset();
        t_auto();
        t_long_reset();
        check(a_valid == 1'b0, "R10 auto cleared by reset", 64'(a_valid), 64'h0);
        t_auto();
        t_abort();
        finish_run();
    end
endmodule